// File: doc/BRIEF.md
# Converter Back-End Power Sequencer

This block governs the digital back end of a two-channel audio converter across power-down, start-up and loss of clock lock. A low level on the power-on input holds everything in reset: the filter is cleared, the serial interface is disabled so its clock and data lines sit low, and converted data is forced to zero. Once the input goes high, the block waits for the first active frame-clock edge. From that edge it counts a fixed number of further frames before it releases the data path. The count depends on whether the converter owns the frame clock or receives it.

An overflow strobe from either channel is held for the frame in which it arrives. It is then delayed by a programmable number of frames, so that it lines up with the filter's group delay. The overflow output stays blank for the first 516 counted frames after each restart. In parallel, a phase watcher counts master-clock cycles between frame-clock rising edges. If two consecutive frames miss the expected ratio, it restarts the sequence as if power had just been applied.

Top module: `conv_pwr_seq`

## Requirements
- R1: While `power_on` is low, from the next clock edge on, `filt_rst`=1, `zero_force`=1, `if_enable`=0 and `ovf_flag`=0. A power-down at any point discards all start-up progress.
- R2: With `master_mode`=1, `zero_force` stays 1 until 516 active frame edges have been counted after the first one, and falls in the cycle after that 517th active edge.
- R3: With `master_mode`=0, `zero_force` falls only after 517 counted edges following the first one, that is after the 518th active edge.
- R4: `ovf_flag` is 0 until 516 edges have been counted after the first active edge, whatever the overflow strobes do.
- R5: `if_enable` goes to 1 in the cycle after `power_on` is first seen high and stays 1 until power-down.
- R6: The active frame edge is a rising `frame_clk` edge when `i2s_fmt`=0 and a falling edge when `i2s_fmt`=1.
- R7: A frame period is measured in master-clock cycles from one `frame_clk` rise to the next. When two consecutive periods each differ from FRAME_RATIO by more than one cycle, the block restarts: `filt_rst`=1 and `zero_force`=1 until the next active edge, and the count then starts again from zero.
- R8: A single out-of-range period, or any period within one cycle of FRAME_RATIO, causes no restart.
- R9: An overflow strobe seen after active edge k, up to and including the cycle of edge k+1, sets `ovf_flag` for one frame. The flag rises in the cycle after edge k+OVF_DELAY and falls in the cycle after edge k+OVF_DELAY+1. Normal operation and the blanking window both still apply.
- R10: `ovf_left` and `ovf_right` have the same effect, and either one alone sets the flag.
- R11: `filt_rst` is 1 during power-down and while waiting for the first active edge after release or after a restart, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| power_on | input | 1 | high = operate, low = power down |
| frame_clk | input | 1 | frame clock level, synchronous to clk |
| master_mode | input | 1 | 1 = block owns the serial clocks, 0 = receives them |
| i2s_fmt | input | 1 | 1 = I2S-style framing (falling edge active) |
| ovf_left | input | 1 | left-channel overflow strobe |
| ovf_right | input | 1 | right-channel overflow strobe |
| zero_force | output | 1 | force converted data to zero |
| if_enable | output | 1 | enable serial interface drivers |
| filt_rst | output | 1 | hold decimation filter in reset |
| ovf_flag | output | 1 | gated, delayed overflow indication |

## Verification
The embedded assertions watch, on every cycle, the following rules:
- power-down forces the quiet output state;
- the interface comes up one cycle after release;
- the frame counter moves only on an active edge;
- the run state is entered only from the correct count for the current mode;
- a phase-loss event is followed by the filter reset;
- the overflow pipeline moves only on frame ticks.

The exact frame number at which data and overflow are released, the edge polarity chosen by the format input, the tolerance of single or one-cycle period errors, and the overflow delay can only be shown by the bench. It drives framed traffic against its behavioural model and checks these milestones by name.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_INIT = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/frame_edge_det.sv
module frame_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk,
  input  logic i2s_fmt,
  output logic rise,
  output logic act
);
  logic fc_q;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fc_q <= 1'b0;
    else        fc_q <= frame_clk;
  end

  always_comb begin
    rise = frame_clk & ~fc_q;
    fall = ~frame_clk & fc_q;
    act  = i2s_fmt ? fall : rise;
  end

  // an active tick only on a real level change of the chosen polarity
  AST_ACT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (frame_clk != $past(frame_clk)) && (frame_clk == !i2s_fmt)); // R6
endmodule

// File: rtl/phase_watch.sv
module phase_watch #(
  parameter int RATIO = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rise,
  output logic loss
);
  localparam int PW = $clog2(RATIO * 2 + 4);
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};
  localparam logic [PW:0]   HI   = (PW+1)'(RATIO + 1);
  localparam logic [PW:0]   LO   = (PW+1)'(RATIO - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          have_q, have_d;
  logic          bad_q, bad_d;
  logic [PW:0]   meas;
  logic          off;

  always_comb begin
    meas   = {1'b0, pcnt_q} + 1'b1;
    off    = (meas > HI) || (meas < LO);
    loss   = run & rise & have_q & off & bad_q;
    pcnt_d = pcnt_q;
    have_d = have_q;
    bad_d  = bad_q;
    if (!run) begin
      pcnt_d = '0;
      have_d = 1'b0;
      bad_d  = 1'b0;
    end else if (rise) begin
      pcnt_d = '0;
      have_d = 1'b1;
      if (have_q) bad_d = off & ~bad_q;
    end else if (pcnt_q != PMAX) begin
      pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      have_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      have_q <= have_d;
      bad_q  <= bad_d;
    end
  end

  // every measured rise restarts the period count
  AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rise) && $past(run) |-> pcnt_q == '0); // R7
endmodule

// File: rtl/startup_fsm.sv
module startup_fsm
  import seq_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int MASTER_INIT = 516,
  parameter int SLAVE_INIT  = 517,
  parameter int OVF_BLANK   = 516
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             power_on,
  input  logic             master_mode,
  input  logic             act,
  input  logic             loss,
  output seq_state_t       st_q,
  output logic             ovf_en
);
  localparam logic [CNT_W-1:0] M_TGT = CNT_W'(MASTER_INIT);
  localparam logic [CNT_W-1:0] S_TGT = CNT_W'(SLAVE_INIT);
  localparam logic [CNT_W-1:0] BLANK = CNT_W'(OVF_BLANK);

  seq_state_t       st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, tgt;
  logic             cnt_en;

  always_comb begin
    tgt     = master_mode ? M_TGT : S_TGT;
    cnt_inc = cnt_q + 1'b1;
    st_d    = st_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (!power_on) begin
      st_d   = ST_OFF;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (st_q == ST_OFF) begin
      st_d = ST_WAIT;
    end else if (loss) begin
      st_d   = ST_WAIT;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (act) begin
      case (st_q)
        ST_WAIT: begin
          st_d   = ST_INIT;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
        ST_INIT: begin
          cnt_d  = cnt_inc;
          cnt_en = 1'b1;
          if (cnt_inc == tgt) st_d = ST_RUN;
        end
        default: ;
      endcase
    end
    ovf_en = (st_q == ST_RUN) | ((st_q == ST_INIT) & (cnt_q >= BLANK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_INIT) && ($past(st_q) == ST_INIT) && !$past(act) |-> $stable(cnt_q)); // R2
  AST_RUN_MASTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) && ($past(st_q) != ST_RUN) && $past(master_mode)
      |-> $past(act) && ($past(cnt_q) + 1'b1 == M_TGT)); // R2
  AST_RUN_SLAVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) && ($past(st_q) != ST_RUN) && !$past(master_mode)
      |-> $past(act) && ($past(cnt_q) + 1'b1 == S_TGT)); // R3
  AST_FIRST_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_INIT) && ($past(st_q) == ST_WAIT) |-> (cnt_q == '0) && $past(act)); // R6
endmodule

// File: rtl/ovf_align.sv
module ovf_align #(
  parameter int DEPTH = 43
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic act,
  input  logic hit_l,
  input  logic hit_r,
  input  logic en,
  output logic flag
);
  logic             sticky_q, sticky_d;
  logic [DEPTH-1:0] pipe_q, pipe_d, pipe_sh;
  logic             hit;

  always_comb hit = hit_l | hit_r;

  generate
    if (DEPTH == 1) begin : g_one
      always_comb pipe_sh = sticky_q | hit;
    end else begin : g_many
      always_comb pipe_sh = {pipe_q[DEPTH-2:0], sticky_q | hit};
    end
  endgenerate

  always_comb begin
    sticky_d = sticky_q;
    pipe_d   = pipe_q;
    if (clr) begin
      sticky_d = 1'b0;
      pipe_d   = '0;
    end else if (act) begin
      sticky_d = 1'b0;
      pipe_d   = pipe_sh;
    end else begin
      sticky_d = sticky_q | hit;
    end
    flag = en & pipe_q[DEPTH-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= 1'b0;
      pipe_q   <= '0;
    end else begin
      sticky_q <= sticky_d;
      pipe_q   <= pipe_d;
    end
  end

  AST_PIPE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(act) && !$past(clr) |-> $stable(pipe_q)); // R9
endmodule

// File: rtl/conv_pwr_seq.sv
module conv_pwr_seq
  import seq_pkg::*;
#(
  parameter int FRAME_RATIO = 256,
  parameter int OVF_DELAY   = 43,
  parameter int CNT_W       = 10,
  parameter int MASTER_INIT = 516,
  parameter int SLAVE_INIT  = 517,
  parameter int OVF_BLANK   = 516
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_on,
  input  logic frame_clk,
  input  logic master_mode,
  input  logic i2s_fmt,
  input  logic ovf_left,
  input  logic ovf_right,
  output logic zero_force,
  output logic if_enable,
  output logic filt_rst,
  output logic ovf_flag
);
  logic       rise, act, loss, ovf_en;
  seq_state_t st;

  frame_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_clk(frame_clk),
    .i2s_fmt  (i2s_fmt),
    .rise     (rise),
    .act      (act)
  );

  phase_watch #(.RATIO(FRAME_RATIO)) u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (power_on),
    .rise (rise),
    .loss (loss)
  );

  startup_fsm #(
    .CNT_W      (CNT_W),
    .MASTER_INIT(MASTER_INIT),
    .SLAVE_INIT (SLAVE_INIT),
    .OVF_BLANK  (OVF_BLANK)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .power_on   (power_on),
    .master_mode(master_mode),
    .act        (act),
    .loss       (loss),
    .st_q       (st),
    .ovf_en     (ovf_en)
  );

  always_comb begin
    zero_force = (st != ST_RUN);
    if_enable  = (st != ST_OFF);
    filt_rst   = (st == ST_OFF) || (st == ST_WAIT);
  end

  ovf_align #(.DEPTH(OVF_DELAY)) u_ovf (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (filt_rst),
    .act  (act),
    .hit_l(ovf_left),
    .hit_r(ovf_right),
    .en   (ovf_en),
    .flag (ovf_flag)
  );

  AST_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !power_on |=> filt_rst && zero_force && !if_enable && !ovf_flag); // R1
  AST_IF_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_on) |=> if_enable); // R5
  AST_LOSS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    loss && power_on && (st != ST_OFF) |=> filt_rst && zero_force); // R7
  AST_NO_OVF_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> !filt_rst && if_enable); // R4
endmodule

// File: tb/test_conv_pwr_seq.sv
module test_conv_pwr_seq;
  localparam int R = 16;
  localparam int D = 43;

  logic clk = 1'b0;
  logic rst_n, power_on, frame_clk, master_mode, i2s_fmt, ovf_left, ovf_right;
  logic zero_force, if_enable, filt_rst, ovf_flag;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  conv_pwr_seq #(.FRAME_RATIO(R), .OVF_DELAY(D)) i_conv_pwr_seq (
    .clk(clk), .rst_n(rst_n), .power_on(power_on), .frame_clk(frame_clk),
    .master_mode(master_mode), .i2s_fmt(i2s_fmt), .ovf_left(ovf_left),
    .ovf_right(ovf_right), .zero_force(zero_force), .if_enable(if_enable),
    .filt_rst(filt_rst), .ovf_flag(ovf_flag)
  );

  // behavioural model: 0 off, 1 waiting for edge, 2 counting, 3 running
  int m_st, m_cnt, m_pcnt;
  bit m_fq, m_have, m_pbad, m_sticky;
  bit m_q[$];

  initial begin
    for (int i = 0; i < D; i++) m_q.push_back(1'b0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pcnt = 0; m_fq = 0; m_have = 0; m_pbad = 0; m_sticky = 0;
      foreach (m_q[i]) m_q[i] = 1'b0;
    end else begin
      bit rise, fall, act, loss, meas_bad;
      int old_st;
      rise = frame_clk && !m_fq;
      fall = !frame_clk && m_fq;
      act  = i2s_fmt ? fall : rise;
      loss = 0;
      old_st = m_st;
      if (!power_on) begin
        m_have = 0; m_pbad = 0; m_pcnt = 0;
      end else if (rise) begin
        if (m_have) begin
          meas_bad = (m_pcnt + 1 > R + 1) || (m_pcnt + 1 < R - 1);
          if (meas_bad && m_pbad) begin loss = 1; m_pbad = 0; end
          else m_pbad = meas_bad;
        end
        m_have = 1; m_pcnt = 0;
      end else m_pcnt++;
      // overflow path uses the state before this edge
      if (old_st <= 1) begin
        m_sticky = 0;
        foreach (m_q[i]) m_q[i] = 1'b0;
      end else if (act) begin
        m_q.push_front(m_sticky | ovf_left | ovf_right);
        void'(m_q.pop_back());
        m_sticky = 0;
      end else m_sticky = m_sticky | ovf_left | ovf_right;
      if (!power_on) begin m_st = 0; m_cnt = 0; end
      else if (old_st == 0) m_st = 1;
      else if (loss) begin m_st = 1; m_cnt = 0; end
      else if (act && old_st == 1) begin m_st = 2; m_cnt = 0; end
      else if (act && old_st == 2) begin
        m_cnt++;
        if (m_cnt == (master_mode ? 516 : 517)) m_st = 3;
      end
      m_fq = frame_clk;
    end
  end

  task automatic chk(input string tag, input logic actual, input logic expv);
    checks++;
    if (actual !== expv) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, actual, expv, $time);
    end
  endtask

  // model comparison on every cycle, away from the active edge
  always @(negedge clk) begin
    bit en;
    en = (m_st == 3) || (m_st == 2 && m_cnt >= 516);
    chk("R2 zero_force vs model", zero_force, m_st != 3);
    chk("R5 if_enable vs model", if_enable, m_st != 0);
    chk("R11 filt_rst vs model", filt_rst, m_st <= 1);
    chk("R9 ovf_flag vs model", ovf_flag, en && m_q[D-1]);
  end

  task automatic frames(input int n, input int per, input bit l = 0, input bit r = 0);
    for (int i = 0; i < n; i++) begin
      frame_clk = 1'b1;
      @(negedge clk);
      ovf_left = l; ovf_right = r;
      @(negedge clk);
      ovf_left = 1'b0; ovf_right = 1'b0;
      repeat (per/2 - 2) @(negedge clk);
      frame_clk = 1'b0;
      repeat (per - per/2) @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 0; power_on = 0; frame_clk = 0; master_mode = 1; i2s_fmt = 0;
    ovf_left = 0; ovf_right = 0;
    repeat (5) @(negedge clk);
    chk("R1 reset zero_force", zero_force, 1'b1);
    chk("R1 reset if_enable", if_enable, 1'b0);
    chk("R11 reset filt_rst", filt_rst, 1'b1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 powered down ovf_flag", ovf_flag, 1'b0);
    // master start-up
    power_on = 1;
    @(negedge clk);
    chk("R5 interface up", if_enable, 1'b1);
    chk("R11 waiting for edge", filt_rst, 1'b1);
    repeat (3) @(negedge clk);
    frames(10, R);
    frames(1, R, 1, 0);
    frames(505, R);
    chk("R2 still zero after 516 edges", zero_force, 1'b1);
    chk("R4 blanked during init", ovf_flag, 1'b0);
    frames(1, R);
    chk("R2 data released after 517 edges", zero_force, 1'b0);
    // overflow alignment
    frames(1, R, 1, 0);
    frames(D - 1, R);
    chk("R9 not yet visible", ovf_flag, 1'b0);
    frames(1, R);
    chk("R9 visible after delay", ovf_flag, 1'b1);
    frames(1, R);
    chk("R9 lasts one frame", ovf_flag, 1'b0);
    frames(1, R, 0, 1);
    frames(D, R);
    chk("R10 right channel alone", ovf_flag, 1'b1);
    frames(1, R);
    chk("R10 right channel clears", ovf_flag, 1'b0);
    // phase tolerance and loss
    frames(1, 20);
    frames(2, R);
    chk("R8 single bad period ignored", zero_force, 1'b0);
    frames(2, R + 1);
    frames(1, R);
    chk("R8 one-cycle error ignored", zero_force, 1'b0);
    frames(2, 24);
    frames(1, R);
    chk("R7 restart filter reset", filt_rst, 1'b1);
    chk("R7 restart zero data", zero_force, 1'b1);
    frames(1, R);
    chk("R11 counting after restart", filt_rst, 1'b0);
    // power-down mid operation
    power_on = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 power-down disables interface", if_enable, 1'b0);
    chk("R1 power-down zero data", zero_force, 1'b1);
    // slave start-up
    master_mode = 0;
    power_on = 1;
    repeat (3) @(negedge clk);
    frames(517, R);
    chk("R3 slave still zero after 517", zero_force, 1'b1);
    frames(1, R);
    chk("R3 slave released after 518", zero_force, 1'b0);
    // falling-edge format
    power_on = 0;
    repeat (3) @(negedge clk);
    master_mode = 1; i2s_fmt = 1;
    power_on = 1;
    repeat (3) @(negedge clk);
    frames(516, R);
    chk("R6 not released before last fall", zero_force, 1'b1);
    frame_clk = 1;
    repeat (R/2) @(negedge clk);
    chk("R6 rising edge does not count", zero_force, 1'b1);
    frame_clk = 0;
    repeat (R/2) @(negedge clk);
    chk("R6 falling edge counts", zero_force, 1'b0);
    power_on = 0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule